// File: doc/BRIEF.md
# Dual-Pixel Panel Timing Generator

This block produces the raster timing for a 1600x1200 flat panel that accepts two pixels in every clock of its roughly 81 MHz data clock. The even-numbered column travels on one pixel output and the odd-numbered column on the other, and both are valid in the same clock. All horizontal counts are therefore in pixel-pair clocks. The default line is 800 active pairs, and the default frame is 1200 active lines.

The generator asks an upstream pixel source for one pair per clock through a request strobe that carries the pair's column and line. The source answers one clock later, and the block passes the answer out alongside the display-enable strobe and the synchronization outputs. Sync widths and porch lengths are run-time inputs. Each one is forced into a legal range, and any correction raises a sticky error flag. The inputs take effect only at a frame boundary, or while the generator is stopped. The horizontal sync polarity can be selected. Vertical sync is always active-high, so the first vertical pulse after start is positive.

Top module: `dual_pixel_timing_gen`

## Requirements
- R1: A synchronous active-high `rst` sets hSync, vSync, de, pixReq, all index outputs, both pixel outputs and cfgErr to 0. It loads the default timing: horizontal sync 96, back porch 152 and front porch 32 pair clocks; vertical sync 3, back porch 46 and front porch 1 lines. It places the counters at the first clock of vertical front porch, so the first active pair follows vFront+vSync+vBack whole lines.
- R2: In every clock where de is 1, evenPix and oddPix equal the evenIn and oddIn values that the upstream source returns one clock after the matching request. In every other clock both pixel outputs are 0.
- R3: Every line lasts H_ACT+hFront+hSync+hBack pair clocks, and every line has the same length. The regions come in this order: active, front porch, sync, back porch. hSync is 1 in the sync region when the latched polarity is 0.
- R4: A frame lasts V_ACT+vFront+vSync+vBack lines, in the order active, front porch, sync, back porch. vSync is active-high and stays 1 for whole lines of the sync region. It changes only at the first clock of a line.
- R5: de is 1 exactly in the clocks of active pairs. colIdx gives the pair column (0..H_ACT-1) and lineIdx gives the line (0..V_ACT-1). Both indices are 0 whenever de is 0.
- R6: pixReq is 1 exactly one clock before each de clock. In that clock, reqCol and reqLine equal the colIdx and lineIdx of the following clock. Both request indices are 0 when pixReq is 0.
- R7: Out-of-range timing inputs are corrected when they are loaded:
  - hSyncLen below 8 becomes 8.
  - hBackLen below 8 becomes 8.
  - hFrontLen 0 becomes 1.
  - vSyncLen 0 becomes 1.
  - vBackLen below 6 becomes 6, and above 125 becomes 125.
  - vFrontLen 0 becomes 1.
- R8: cfgErr becomes 1 at any load that corrects a value. It stays 1 until reset.
- R9: The timing inputs are loaded only in two cases: while enable is 0, and at the clock where the counters wrap from the last clock of a frame to the first. A change at any other time has no effect until the next frame.
- R10: When the latched hSyncNeg is 1, hSync is active-low and idles at 1. hSyncNeg is latched only while enable is 0. A change while enable is 1 has no effect until enable is dropped.
- R11: While enable is 0, the counters are held at the first clock of vertical front porch. Two clocks later, de, pixReq and vSync are 0 and hSync sits at its idle level. After enable returns to 1, timing restarts from that point.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pair clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Run the raster when 1 |
| hSyncLen | input | 8 | Horizontal sync width, pair clocks |
| hBackLen | input | 9 | Horizontal back porch, pair clocks |
| hFrontLen | input | 8 | Horizontal front porch, pair clocks |
| vSyncLen | input | 6 | Vertical sync width, lines |
| vBackLen | input | 7 | Vertical back porch, lines |
| vFrontLen | input | 6 | Vertical front porch, lines |
| hSyncNeg | input | 1 | 1 selects active-low horizontal sync |
| evenIn | input | PIX_W | Even pixel from upstream, one clock after request |
| oddIn | input | PIX_W | Odd pixel from upstream, one clock after request |
| pixReq | output | 1 | Request for one pixel pair |
| reqCol | output | COL_W | Pair column being requested |
| reqLine | output | LINE_W | Line being requested |
| hSync | output | 1 | Horizontal sync |
| vSync | output | 1 | Vertical sync, active-high |
| de | output | 1 | Display enable |
| colIdx | output | COL_W | Pair column of the pair on the pixel outputs |
| lineIdx | output | LINE_W | Line of the pair on the pixel outputs |
| evenPix | output | PIX_W | Even pixel out |
| oddPix | output | PIX_W | Odd pixel out |
| cfgErr | output | 1 | Sticky flag: a timing input was corrected |

## Verification
Two events can land in the same clock: the frame wrap that loads new timing, and a change of the timing inputs in the middle of a frame. The bench changes the sync width, the porch length and the polarity part-way through a running frame. A bench reference model, updated only at its own frame wrap, then decides whether each line of the rest of the frame still carries the old widths and whether the next frame carries the new ones. The same comparison runs for corrected inputs, where the frame length after correction and the error flag must agree with the model from the first cycle after the load.

// File: rtl/tg_pkg.sv
package tg_pkg;
  // widths of the run-time timing inputs
  localparam int HSYNC_W  = 8;
  localparam int HBACK_W  = 9;
  localparam int HFRONT_W = 8;
  localparam int VSYNC_W  = 6;
  localparam int VBACK_W  = 7;
  localparam int VFRONT_W = 6;

  // legal limits
  localparam logic [HSYNC_W-1:0]  HSYNC_MIN  = 8;
  localparam logic [HBACK_W-1:0]  HBACK_MIN  = 8;
  localparam logic [HFRONT_W-1:0] HFRONT_MIN = 1;
  localparam logic [VSYNC_W-1:0]  VSYNC_MIN  = 1;
  localparam logic [VBACK_W-1:0]  VBACK_MIN  = 6;
  localparam logic [VBACK_W-1:0]  VBACK_MAX  = 125;
  localparam logic [VFRONT_W-1:0] VFRONT_MIN = 1;

  // reset timing
  localparam logic [HSYNC_W-1:0]  HSYNC_DEF  = 96;
  localparam logic [HBACK_W-1:0]  HBACK_DEF  = 152;
  localparam logic [HFRONT_W-1:0] HFRONT_DEF = 32;
  localparam logic [VSYNC_W-1:0]  VSYNC_DEF  = 3;
  localparam logic [VBACK_W-1:0]  VBACK_DEF  = 46;
  localparam logic [VFRONT_W-1:0] VFRONT_DEF = 1;

  typedef struct packed {
    logic [HSYNC_W-1:0]  hSync;
    logic [HBACK_W-1:0]  hBack;
    logic [HFRONT_W-1:0] hFront;
    logic [VSYNC_W-1:0]  vSync;
    logic [VBACK_W-1:0]  vBack;
    logic [VFRONT_W-1:0] vFront;
  } tgCfg_t;

  // strobes from control to datapath
  typedef struct packed {
    logic active;
    logic hsZone;
    logic vsZone;
  } tgStrobe_t;
endpackage

// File: rtl/tg_cfg.sv
module tg_cfg
  import tg_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   loadCfg,
  input  logic   loadPol,
  input  tgCfg_t cfgIn,
  input  logic   negIn,
  output tgCfg_t cfgQ,
  output logic   negQ,
  output logic   errQ
);
  tgCfg_t fixedCfg;
  logic   clampHit;

  always_comb begin
    fixedCfg = cfgIn;
    clampHit = 1'b0;
    if (cfgIn.hSync < HSYNC_MIN) begin
      fixedCfg.hSync = HSYNC_MIN;
      clampHit = 1'b1;
    end
    if (cfgIn.hBack < HBACK_MIN) begin
      fixedCfg.hBack = HBACK_MIN;
      clampHit = 1'b1;
    end
    if (cfgIn.hFront < HFRONT_MIN) begin
      fixedCfg.hFront = HFRONT_MIN;
      clampHit = 1'b1;
    end
    if (cfgIn.vSync < VSYNC_MIN) begin
      fixedCfg.vSync = VSYNC_MIN;
      clampHit = 1'b1;
    end
    if (cfgIn.vBack < VBACK_MIN) begin
      fixedCfg.vBack = VBACK_MIN;
      clampHit = 1'b1;
    end else if (cfgIn.vBack > VBACK_MAX) begin
      fixedCfg.vBack = VBACK_MAX;
      clampHit = 1'b1;
    end
    if (cfgIn.vFront < VFRONT_MIN) begin
      fixedCfg.vFront = VFRONT_MIN;
      clampHit = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cfgQ <= '{hSync: HSYNC_DEF, hBack: HBACK_DEF, hFront: HFRONT_DEF,
                vSync: VSYNC_DEF, vBack: VBACK_DEF, vFront: VFRONT_DEF};
      negQ <= 1'b0;
      errQ <= 1'b0;
    end else begin
      if (loadCfg) begin
        cfgQ <= fixedCfg;
        if (clampHit) errQ <= 1'b1;
      end
      if (loadPol) negQ <= negIn;
    end
  end

  assert_cfg_legal_R7: assert property (@(posedge clk) disable iff (rst)
    cfgQ.hSync >= HSYNC_MIN && cfgQ.hBack >= HBACK_MIN && cfgQ.hFront >= HFRONT_MIN &&
    cfgQ.vSync >= VSYNC_MIN && cfgQ.vBack >= VBACK_MIN && cfgQ.vBack <= VBACK_MAX &&
    cfgQ.vFront >= VFRONT_MIN);

  assert_err_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) && $past(errQ) |-> errQ);

  assert_cfg_frozen_R9: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) && !$past(loadCfg) |-> $stable(cfgQ));

  assert_pol_frozen_R10: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) && !$past(loadPol) |-> $stable(negQ));
endmodule

// File: rtl/tg_ctrl.sv
module tg_ctrl
  import tg_pkg::*;
#(
  parameter  int H_ACT  = 800,
  parameter  int V_ACT  = 1200,
  localparam int COL_W  = (H_ACT > 1) ? $clog2(H_ACT) : 1,
  localparam int LINE_W = (V_ACT > 1) ? $clog2(V_ACT) : 1,
  localparam int H_MAX  = H_ACT + (2**HSYNC_W - 1) + (2**HBACK_W - 1) + (2**HFRONT_W - 1),
  localparam int V_MAX  = V_ACT + (2**VSYNC_W - 1) + int'(VBACK_MAX) + (2**VFRONT_W - 1),
  localparam int HCNT_W = $clog2(H_MAX + 1),
  localparam int VCNT_W = $clog2(V_MAX + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enable,
  input  tgCfg_t            cfg,
  output tgStrobe_t         strb,
  output logic [COL_W-1:0]  col,
  output logic [LINE_W-1:0] lineIdx,
  output logic              frameWrap
);
  logic [HCNT_W-1:0] hCnt, hsBeg, hsEnd, hTotal;
  logic [VCNT_W-1:0] vCnt, vsBeg, vsEnd, vTotal;
  logic hLast, vLast, inH, inV;

  always_comb begin
    hsBeg  = HCNT_W'(H_ACT) + HCNT_W'(cfg.hFront);
    hsEnd  = hsBeg + HCNT_W'(cfg.hSync);
    hTotal = hsEnd + HCNT_W'(cfg.hBack);
    vsBeg  = VCNT_W'(V_ACT) + VCNT_W'(cfg.vFront);
    vsEnd  = vsBeg + VCNT_W'(cfg.vSync);
    vTotal = vsEnd + VCNT_W'(cfg.vBack);
    hLast  = (hCnt == hTotal - HCNT_W'(1));
    vLast  = (vCnt == vTotal - VCNT_W'(1));
    inH    = (hCnt < HCNT_W'(H_ACT));
    inV    = (vCnt < VCNT_W'(V_ACT));
  end

  always_ff @(posedge clk) begin
    if (rst || !enable) begin
      hCnt <= '0;
      vCnt <= VCNT_W'(V_ACT);
    end else if (hLast) begin
      hCnt <= '0;
      vCnt <= vLast ? '0 : vCnt + VCNT_W'(1);
    end else begin
      hCnt <= hCnt + HCNT_W'(1);
    end
  end

  always_comb begin
    strb.active = enable && inH && inV;
    strb.hsZone = enable && (hCnt >= hsBeg) && (hCnt < hsEnd);
    strb.vsZone = enable && (vCnt >= vsBeg) && (vCnt < vsEnd);
    col         = strb.active ? hCnt[COL_W-1:0] : '0;
    lineIdx     = strb.active ? vCnt[LINE_W-1:0] : '0;
    frameWrap   = enable && hLast && vLast;
  end

  assert_hcnt_bound_R3: assert property (@(posedge clk) disable iff (rst)
    enable |-> hCnt < hTotal);

  assert_active_not_sync_R3: assert property (@(posedge clk) disable iff (rst)
    $onehot0({strb.active, strb.hsZone}));

  assert_vs_line_start_R4: assert property (@(posedge clk) disable iff (rst)
    enable && $past(enable) && (strb.vsZone != $past(strb.vsZone)) |-> hCnt == '0);

  assert_idle_position_R11: assert property (@(posedge clk) disable iff (rst)
    !$past(enable) |-> (hCnt == '0 && vCnt == VCNT_W'(V_ACT)));
endmodule

// File: rtl/tg_dp.sv
module tg_dp
  import tg_pkg::*;
#(
  parameter int PIX_W  = 18,
  parameter int COL_W  = 10,
  parameter int LINE_W = 11
) (
  input  logic              clk,
  input  logic              rst,
  input  tgStrobe_t         strb,
  input  logic [COL_W-1:0]  col,
  input  logic [LINE_W-1:0] lineIdx,
  input  logic              hsNeg,
  input  logic [PIX_W-1:0]  evenIn,
  input  logic [PIX_W-1:0]  oddIn,
  output logic              pixReq,
  output logic [COL_W-1:0]  reqCol,
  output logic [LINE_W-1:0] reqLine,
  output logic              hSyncO,
  output logic              vSyncO,
  output logic              deO,
  output logic [COL_W-1:0]  colO,
  output logic [LINE_W-1:0] lineO,
  output logic [PIX_W-1:0]  evenPix,
  output logic [PIX_W-1:0]  oddPix
);
  logic hsZone1, vsZone1;

  // stage 1: request to upstream
  always_ff @(posedge clk) begin
    if (rst) begin
      pixReq  <= 1'b0;
      reqCol  <= '0;
      reqLine <= '0;
      hsZone1 <= 1'b0;
      vsZone1 <= 1'b0;
    end else begin
      pixReq  <= strb.active;
      reqCol  <= col;
      reqLine <= lineIdx;
      hsZone1 <= strb.hsZone;
      vsZone1 <= strb.vsZone;
    end
  end

  // stage 2: aligned with upstream answer
  always_ff @(posedge clk) begin
    if (rst) begin
      deO    <= 1'b0;
      colO   <= '0;
      lineO  <= '0;
      hSyncO <= 1'b0;
      vSyncO <= 1'b0;
    end else begin
      deO    <= pixReq;
      colO   <= reqCol;
      lineO  <= reqLine;
      hSyncO <= hsZone1 ^ hsNeg;
      vSyncO <= vsZone1;
    end
  end

  always_comb begin
    evenPix = deO ? evenIn : '0;
    oddPix  = deO ? oddIn  : '0;
  end

  assert_req_then_de_R6: assert property (@(posedge clk) disable iff (rst)
    pixReq |=> deO);

  assert_noreq_then_quiet_R6: assert property (@(posedge clk) disable iff (rst)
    !pixReq |=> !deO);

  assert_idx_idle_R5: assert property (@(posedge clk) disable iff (rst)
    !deO |-> (colO == '0 && lineO == '0));

  assert_reqidx_idle_R6: assert property (@(posedge clk) disable iff (rst)
    !pixReq |-> (reqCol == '0 && reqLine == '0));
endmodule

// File: rtl/dual_pixel_timing_gen.sv
module dual_pixel_timing_gen
  import tg_pkg::*;
#(
  parameter  int H_ACT  = 800,
  parameter  int V_ACT  = 1200,
  parameter  int PIX_W  = 18,
  localparam int COL_W  = (H_ACT > 1) ? $clog2(H_ACT) : 1,
  localparam int LINE_W = (V_ACT > 1) ? $clog2(V_ACT) : 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                enable,
  input  logic [HSYNC_W-1:0]  hSyncLen,
  input  logic [HBACK_W-1:0]  hBackLen,
  input  logic [HFRONT_W-1:0] hFrontLen,
  input  logic [VSYNC_W-1:0]  vSyncLen,
  input  logic [VBACK_W-1:0]  vBackLen,
  input  logic [VFRONT_W-1:0] vFrontLen,
  input  logic                hSyncNeg,
  input  logic [PIX_W-1:0]    evenIn,
  input  logic [PIX_W-1:0]    oddIn,
  output logic                pixReq,
  output logic [COL_W-1:0]    reqCol,
  output logic [LINE_W-1:0]   reqLine,
  output logic                hSync,
  output logic                vSync,
  output logic                de,
  output logic [COL_W-1:0]    colIdx,
  output logic [LINE_W-1:0]   lineIdx,
  output logic [PIX_W-1:0]    evenPix,
  output logic [PIX_W-1:0]    oddPix,
  output logic                cfgErr
);
  tgCfg_t            cfgIn, cfgQ;
  tgStrobe_t         strb;
  logic [COL_W-1:0]  ctrlCol;
  logic [LINE_W-1:0] ctrlLine;
  logic              frameWrap, hsNegQ, loadCfg, loadPol;

  assign cfgIn   = '{hSync: hSyncLen, hBack: hBackLen, hFront: hFrontLen,
                     vSync: vSyncLen, vBack: vBackLen, vFront: vFrontLen};
  assign loadCfg = !enable || frameWrap;
  assign loadPol = !enable;

  tg_cfg uCfg (
    .clk(clk), .rst(rst), .loadCfg(loadCfg), .loadPol(loadPol),
    .cfgIn(cfgIn), .negIn(hSyncNeg), .cfgQ(cfgQ), .negQ(hsNegQ), .errQ(cfgErr)
  );

  tg_ctrl #(.H_ACT(H_ACT), .V_ACT(V_ACT)) uCtrl (
    .clk(clk), .rst(rst), .enable(enable), .cfg(cfgQ), .strb(strb),
    .col(ctrlCol), .lineIdx(ctrlLine), .frameWrap(frameWrap)
  );

  tg_dp #(.PIX_W(PIX_W), .COL_W(COL_W), .LINE_W(LINE_W)) uDp (
    .clk(clk), .rst(rst), .strb(strb), .col(ctrlCol), .lineIdx(ctrlLine),
    .hsNeg(hsNegQ), .evenIn(evenIn), .oddIn(oddIn),
    .pixReq(pixReq), .reqCol(reqCol), .reqLine(reqLine),
    .hSyncO(hSync), .vSyncO(vSync), .deO(de), .colO(colIdx), .lineO(lineIdx),
    .evenPix(evenPix), .oddPix(oddPix)
  );
endmodule

// File: tb/sim_dual_pixel_timing_gen.sv
module sim_dual_pixel_timing_gen;
  localparam int HA = 8;
  localparam int VA = 4;
  localparam int PW = 18;
  localparam int CW = 3;
  localparam int LW = 2;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst = 1'b1, enable = 1'b0, hSyncNeg = 1'b0;
  logic [7:0] hSyncLen = 8, hFrontLen = 1;
  logic [8:0] hBackLen = 8;
  logic [5:0] vSyncLen = 1, vFrontLen = 1;
  logic [6:0] vBackLen = 6;
  logic [PW-1:0] evenIn = '0, oddIn = '0;
  logic pixReq, hSync, vSync, de, cfgErr;
  logic [CW-1:0] reqCol, colIdx;
  logic [LW-1:0] reqLine, lineIdx;
  logic [PW-1:0] evenPix, oddPix;

  dual_pixel_timing_gen #(.H_ACT(HA), .V_ACT(VA), .PIX_W(PW)) u0 (
    .clk(clk), .rst(rst), .enable(enable), .hSyncLen(hSyncLen), .hBackLen(hBackLen),
    .hFrontLen(hFrontLen), .vSyncLen(vSyncLen), .vBackLen(vBackLen), .vFrontLen(vFrontLen),
    .hSyncNeg(hSyncNeg), .evenIn(evenIn), .oddIn(oddIn), .pixReq(pixReq), .reqCol(reqCol),
    .reqLine(reqLine), .hSync(hSync), .vSync(vSync), .de(de), .colIdx(colIdx),
    .lineIdx(lineIdx), .evenPix(evenPix), .oddPix(oddPix), .cfgErr(cfgErr)
  );

  function automatic int pat(int l, int c, int o);
    return (l * 64 + c * 2 + o + 5) % (1 << PW);
  endfunction

  // upstream source: answers a request one clock later
  always @(posedge clk) begin
    if (pixReq) begin
      evenIn <= PW'(pat(int'(reqLine), int'(reqCol), 0));
      oddIn  <= PW'(pat(int'(reqLine), int'(reqCol), 1));
    end
  end

  int checks = 0, failures = 0;
  bit done = 1'b0;
  string phase = "R1 reset";

  // reference model state
  int cHs, cHb, cHf, cVs, cVb, cVf;
  bit mNeg, mErr;
  int mh, mv;
  bit s1a, s1h, s1v, s2a, s2hs, s2vs;
  int s1c, s1l, s2c, s2l;

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s [%s] actual=%0d expected=%0d", tag, phase, act, exp);
    end
  endtask

  task automatic loadModel();
    bit bad = 1'b0;
    cHs = int'(hSyncLen);  if (cHs < 8) begin cHs = 8; bad = 1'b1; end
    cHb = int'(hBackLen);  if (cHb < 8) begin cHb = 8; bad = 1'b1; end
    cHf = int'(hFrontLen); if (cHf < 1) begin cHf = 1; bad = 1'b1; end
    cVs = int'(vSyncLen);  if (cVs < 1) begin cVs = 1; bad = 1'b1; end
    cVb = int'(vBackLen);
    if (cVb < 6) begin cVb = 6; bad = 1'b1; end
    if (cVb > 125) begin cVb = 125; bad = 1'b1; end
    cVf = int'(vFrontLen); if (cVf < 1) begin cVf = 1; bad = 1'b1; end
    if (bad) mErr = 1'b1;
  endtask

  task automatic modelEdge();
    int L, T;
    if (rst) begin
      s1a = 0; s1h = 0; s1v = 0; s1c = 0; s1l = 0;
      s2a = 0; s2hs = 0; s2vs = 0; s2c = 0; s2l = 0;
      cHs = 96; cHb = 152; cHf = 32; cVs = 3; cVb = 46; cVf = 1;
      mNeg = 0; mErr = 0; mh = 0; mv = VA;
    end else begin
      L = HA + cHf + cHs + cHb;
      T = VA + cVf + cVs + cVb;
      s2a = s1a; s2c = s1c; s2l = s1l; s2hs = s1h ^ mNeg; s2vs = s1v;
      if (enable) begin
        s1a = (mh < HA) && (mv < VA);
        s1h = (mh >= HA + cHf) && (mh < HA + cHf + cHs);
        s1v = (mv >= VA + cVf) && (mv < VA + cVf + cVs);
        s1c = s1a ? mh : 0;
        s1l = s1a ? mv : 0;
      end else begin
        s1a = 0; s1h = 0; s1v = 0; s1c = 0; s1l = 0;
      end
      if (!enable) begin
        loadModel(); mNeg = hSyncNeg; mh = 0; mv = VA;
      end else if (mh == L - 1) begin
        mh = 0;
        if (mv == T - 1) begin mv = 0; loadModel(); end
        else mv++;
      end else mh++;
    end
  endtask

  task automatic compareAll();
    check("R3 hSync", int'(hSync), int'(s2hs));
    check("R4 vSync", int'(vSync), int'(s2vs));
    check("R5 de", int'(de), int'(s2a));
    check("R5 colIdx", int'(colIdx), s2c);
    check("R5 lineIdx", int'(lineIdx), s2l);
    check("R6 pixReq", int'(pixReq), int'(s1a));
    check("R6 reqCol", int'(reqCol), s1c);
    check("R6 reqLine", int'(reqLine), s1l);
    check("R2 evenPix", int'(evenPix), s2a ? pat(s2l, s2c, 0) : 0);
    check("R2 oddPix", int'(oddPix), s2a ? pat(s2l, s2c, 1) : 0);
    check("R8 cfgErr", int'(cfgErr), int'(mErr));
  endtask

  task automatic tick(int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      modelEdge();
      @(negedge clk);
      compareAll();
    end
  endtask

  initial begin
    #800000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog [%s] actual=hung expected=finished", phase);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    phase = "R1 reset";
    tick(3);
    rst = 1'b0;
    phase = "R11 idle";
    tick(5);
    phase = "R1 start from vertical front porch";
    enable = 1'b1;
    tick(320);
    phase = "R3 R4 R5 pattern A";
    tick(600);
    phase = "R9 mid-run update, R10 polarity held";
    hSyncLen = 12; hFrontLen = 3; vSyncLen = 2; hSyncNeg = 1'b1;
    tick(1000);
    phase = "R11 disable mid-frame";
    enable = 1'b0;
    tick(10);
    phase = "R10 active-low hsync";
    enable = 1'b1;
    tick(800);
    phase = "R7 clamp high vback";
    enable = 1'b0;
    hSyncLen = 3; hBackLen = 2; hFrontLen = 0; vSyncLen = 0; vBackLen = 127; vFrontLen = 0;
    hSyncNeg = 1'b0;
    tick(3);
    enable = 1'b1;
    tick(3500);
    phase = "R7 clamp low vback";
    enable = 1'b0;
    vBackLen = 2; hSyncLen = 10; hBackLen = 9;
    tick(3);
    enable = 1'b1;
    tick(700);
    phase = "R8 sticky after legal load";
    enable = 1'b0;
    hSyncLen = 8; hBackLen = 8; hFrontLen = 1; vSyncLen = 1; vBackLen = 6; vFrontLen = 1;
    tick(3);
    enable = 1'b1;
    tick(100);
    phase = "R1 reset clears";
    rst = 1'b1;
    tick(3);
    rst = 1'b0;
    enable = 1'b0;
    tick(3);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule